// File: doc/BRIEF.md
# Shifted-Operand Data-Processing ALU

This block is the data-processing stage of a 32-bit load/store RISC core. Each cycle it takes a first register value, a second value with a shift type and shift amount, a four-bit operation code, a set-flags control and the current negative/zero/carry/overflow flags. On the next clock edge it presents a result, a result-write-enable and the next flag values. The second value always goes through a barrel shifter before it reaches the arithmetic and logic unit. The shifter's carry-out is the carry flag source for logical, test and move operations.

Sixteen operations are provided. Six are arithmetic, including reverse subtraction with and without carry. Four are logical, including bit-clear. Two are moves. Four are compare or test operations. The compare and test group always updates the flags and never requests a register write. Every other operation touches the flags only when set-flags is high. Decode, the register file, conditional execution and memory access belong to the surrounding core.

Top module: `shifted_alu`

## Requirements
- R1: All outputs are registered with one cycle of latency. An asynchronous active-low reset clears `result`, `result_we` and `flags_out` to zero.
- R2: The shifter transforms `opnd_b` according to `shift_kind`: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. The amount `shift_amt` ranges from 0 to 31, and an amount of 0 passes the operand through unchanged.
- R3: The shifter carry-out equals the incoming C flag when the amount is 0. Otherwise it equals the last bit shifted out, which for rotate is bit 31 of the rotated value.
- R4: The arithmetic opcodes are 0100 ADD (a+s), 0101 ADC (a+s+C), 0010 SUB (a-s), 0110 SBC (a-s-!C), 0011 RSB (s-a) and 0111 RSC (s-a-!C). Here s is the shifted operand.
- R5: The logical and move opcodes are 0000 AND, 0001 EOR, 1100 ORR, 1110 BIC (a & ~s), 1101 MOV (s) and 1111 MVN (~s). MOV and MVN ignore `opnd_a`.
- R6: The opcodes 1000 TST (a&s), 1001 TEQ (a^s), 1010 CMP (a-s) and 1011 CMN (a+s) never assert `result_we`. Every other opcode asserts it. For these four, `result` shows the internal value.
- R7: In `flags_in` and `flags_out`, bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. The flags are recomputed when `set_flags` is 1 or the opcode is in the compare/test group. Otherwise `flags_out` equals the registered `flags_in`.
- R8: When updated, N equals bit 31 of the result and Z is 1 exactly when the 32-bit result is zero. The compare/test group computes both from its internal value.
- R9: For arithmetic operations, C is the unsigned carry for additions and is 1 when no borrow occurs for subtractions. V is 1 on signed two's-complement overflow.
- R10: For logical, test and move operations, C takes the shifter carry-out and V keeps the incoming value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second operand, before shifting |
| shift_kind | input | 2 | Shift type for the second operand |
| shift_amt | input | 5 | Shift amount, 0 to 31 |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Request flag update |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Registered result |
| result_we | output | 1 | Registered result write enable |
| flags_out | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
Two functions can land on the same cycle and interact: the shifter's carry-out and the flag update decision. A logical, test or move operation with a nonzero shift must pass the shifted-out bit into C, but only when the flags are actually being updated. The bench provokes this by driving shifts whose last shifted-out bit differs from the incoming C. It does so both with set-flags low, where C must stay as it was, and with set-flags high or a test opcode, where C must follow the shifter. A behavioural per-cycle model in the bench judges every cycle, and directed and random patterns cover a shift amount of zero on the same paths.

// File: rtl/salu_pkg.sv
package salu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_EOR = 4'h1,
        OP_SUB = 4'h2,
        OP_RSB = 4'h3,
        OP_ADD = 4'h4,
        OP_ADC = 4'h5,
        OP_SBC = 4'h6,
        OP_RSC = 4'h7,
        OP_TST = 4'h8,
        OP_TEQ = 4'h9,
        OP_CMP = 4'hA,
        OP_CMN = 4'hB,
        OP_ORR = 4'hC,
        OP_MOV = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // flag-only group: opcodes 10xx
    function automatic logic op_is_compare(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
    endfunction

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
    import salu_pkg::*;
#(
    parameter int unsigned W = 32,
    localparam int unsigned SH_W = $clog2(W)
) (
    input  logic [W-1:0]    opnd,
    input  logic [1:0]      kind,
    input  logic [SH_W-1:0] amt,
    input  logic            c_in,
    output logic [W-1:0]    shifted,
    output logic            c_out
);

    logic [W-1:0]    work;
    logic [SH_W-1:0] idx_left;
    logic [SH_W-1:0] idx_right;

    // log-staged barrel: stage i moves by 2**i when amt[i] is set
    always_comb begin
        work = opnd;
        for (int i = 0; i < int'(SH_W); i++) begin
            if (amt[i]) begin
                unique case (shift_kind_e'(kind))
                    SH_LSL: work = work << (1 << i);
                    SH_LSR: work = work >> (1 << i);
                    SH_ASR: work = W'($signed(work) >>> (1 << i));
                    SH_ROR: work = (work >> (1 << i)) | (work << (W - (1 << i)));
                    default: work = work;
                endcase
            end
        end
        shifted = work;
    end

    // carry taken straight from the unshifted operand, in parallel with the stages
    always_comb begin
        idx_left  = '0 - amt;
        idx_right = amt - 1'b1;
        if (amt == '0) begin
            c_out = c_in;
        end else if (shift_kind_e'(kind) == SH_LSL) begin
            c_out = opnd[idx_left];
        end else begin
            c_out = opnd[idx_right];
        end
    end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import salu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_s,
    input  logic [3:0]   op,
    input  logic         c_in,
    output logic [W-1:0] value,
    output logic         add_c,
    output logic         add_v
);

    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_ci;
    logic [W:0]   sum;
    logic [W-1:0] logic_val;

    // one shared adder; subtraction by inverting one side, reverse by swapping
    always_comb begin
        add_x  = opnd_a;
        add_y  = opnd_s;
        add_ci = 1'b0;
        unique case (alu_op_e'(op))
            OP_ADD, OP_CMN: begin add_x = opnd_a; add_y = opnd_s;  add_ci = 1'b0; end
            OP_ADC:         begin add_x = opnd_a; add_y = opnd_s;  add_ci = c_in; end
            OP_SUB, OP_CMP: begin add_x = opnd_a; add_y = ~opnd_s; add_ci = 1'b1; end
            OP_SBC:         begin add_x = opnd_a; add_y = ~opnd_s; add_ci = c_in; end
            OP_RSB:         begin add_x = opnd_s; add_y = ~opnd_a; add_ci = 1'b1; end
            OP_RSC:         begin add_x = opnd_s; add_y = ~opnd_a; add_ci = c_in; end
            default:        begin add_x = opnd_a; add_y = opnd_s;  add_ci = 1'b0; end
        endcase
        sum   = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
        add_c = sum[W];
        add_v = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);
    end

    always_comb begin
        unique case (alu_op_e'(op))
            OP_AND, OP_TST: logic_val = opnd_a & opnd_s;
            OP_EOR, OP_TEQ: logic_val = opnd_a ^ opnd_s;
            OP_ORR:         logic_val = opnd_a | opnd_s;
            OP_BIC:         logic_val = opnd_a & ~opnd_s;
            OP_MOV:         logic_val = opnd_s;
            OP_MVN:         logic_val = ~opnd_s;
            default:        logic_val = opnd_a & opnd_s;
        endcase
        value = op_is_arith(op) ? sum[W-1:0] : logic_val;
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import salu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] value,
    input  logic [3:0]   op,
    input  logic         set_flags,
    input  flags_t       flags_cur,
    input  logic         sh_c,
    input  logic         add_c,
    input  logic         add_v,
    output flags_t       flags_nxt,
    output logic         write_en
);

    logic update;
    logic arith;

    always_comb begin
        arith    = op_is_arith(op);
        update   = set_flags || op_is_compare(op);
        write_en = !op_is_compare(op);
        if (update) begin
            flags_nxt.n = value[W-1];
            flags_nxt.z = (value == '0);
            flags_nxt.c = arith ? add_c : sh_c;
            flags_nxt.v = arith ? add_v : flags_cur.v;
        end else begin
            flags_nxt = flags_cur;
        end
    end

endmodule

// File: rtl/shifted_alu.sv
module shifted_alu
    import salu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [1:0]          shift_kind,
    input  logic [SHAMT_W-1:0]  shift_amt,
    input  logic [3:0]          opcode,
    input  logic                set_flags,
    input  logic [3:0]          flags_in,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output logic [3:0]          flags_out
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              we;
        flags_t            flags;
    } stage_t;

    stage_t            stage_d;
    stage_t            stage_q;
    flags_t            flags_cur;
    flags_t            flags_nxt;
    logic [DATA_W-1:0] shifted;
    logic              sh_c;
    logic [DATA_W-1:0] value;
    logic              add_c;
    logic              add_v;
    logic              write_en;

    assign flags_cur = flags_t'(flags_in);

    alu_shifter #(.W(DATA_W)) u_shifter (
        .opnd    (opnd_b),
        .kind    (shift_kind),
        .amt     (shift_amt),
        .c_in    (flags_cur.c),
        .shifted (shifted),
        .c_out   (sh_c)
    );

    alu_datapath #(.W(DATA_W)) u_datapath (
        .opnd_a (opnd_a),
        .opnd_s (shifted),
        .op     (opcode),
        .c_in   (flags_cur.c),
        .value  (value),
        .add_c  (add_c),
        .add_v  (add_v)
    );

    alu_flag_unit #(.W(DATA_W)) u_flags (
        .value     (value),
        .op        (opcode),
        .set_flags (set_flags),
        .flags_cur (flags_cur),
        .sh_c      (sh_c),
        .add_c     (add_c),
        .add_v     (add_v),
        .flags_nxt (flags_nxt),
        .write_en  (write_en)
    );

    always_comb begin
        stage_d.value = value;
        stage_d.we    = write_en;
        stage_d.flags = flags_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result    = stage_q.value;
    assign result_we = stage_q.we;
    assign flags_out = stage_q.flags;

endmodule

// File: rtl/salu_checker.sv
module salu_checker #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DATA_W-1:0]   opnd_a,
    input logic [DATA_W-1:0]   opnd_b,
    input logic [1:0]          shift_kind,
    input logic [SHAMT_W-1:0]  shift_amt,
    input logic [3:0]          opcode,
    input logic                set_flags,
    input logic [3:0]          flags_in,
    input logic [DATA_W-1:0]   result,
    input logic                result_we,
    input logic [3:0]          flags_out
);

    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    // R6: flag-only group never requests a write
    a_r6_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(opcode[3:2] == 2'b10)) |-> !result_we);

    // R6: every other opcode requests a write
    a_r6_other_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(opcode[3:2] != 2'b10)) |-> result_we);

    // R7: no update request leaves the flags as they came in
    a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(!set_flags && opcode[3:2] != 2'b10)) |-> (flags_out == $past(flags_in)));

    // R8: updated N and Z agree with the presented result
    a_r8_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(set_flags || opcode[3:2] == 2'b10))
        |-> (flags_out[3] == result[DATA_W-1]) && (flags_out[2] == (result == '0)));

    // R10: logical, test and move keep V
    a_r10_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(opcode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}))
        |-> (flags_out[0] == $past(flags_in[0])));

    logic unused_ok;
    assign unused_ok = ^{opnd_a, opnd_b, shift_kind, shift_amt};

endmodule

bind shifted_alu salu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .shift_kind (shift_kind),
    .shift_amt  (shift_amt),
    .opcode     (opcode),
    .set_flags  (set_flags),
    .flags_in   (flags_in),
    .result     (result),
    .result_we  (result_we),
    .flags_out  (flags_out)
);

// File: tb/shifted_alu_tb.sv
module shifted_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    shifted_alu u_dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .opcode(opcode),
        .set_flags(set_flags), .flags_in(flags_in),
        .result(result), .result_we(result_we), .flags_out(flags_out)
    );

    // behavioural reference for one cycle
    function automatic void model(
        input logic [31:0] a, input logic [31:0] b, input logic [1:0] k,
        input logic [4:0] n, input logic [3:0] op, input logic sf, input logic [3:0] fin,
        output logic [31:0] r, output logic we, output logic [3:0] fo);
        logic [31:0] s;
        logic sc, c, v;
        int ni;
        longint ux, uy, sx, sy, u, sv, cy;
        bit arith, sub;
        ni = int'(n);
        if (ni == 0) begin
            s = b; sc = fin[1];
        end else begin
            case (k)
                2'd0: begin s = b << ni; sc = b[32-ni]; end
                2'd1: begin s = b >> ni; sc = b[ni-1]; end
                2'd2: begin s = $signed(b) >>> ni; sc = b[ni-1]; end
                default: begin s = (b >> ni) | (b << (32 - ni)); sc = s[31]; end
            endcase
        end
        arith = 1; sub = 0; cy = 0;
        ux = longint'(a); uy = longint'(s);
        case (op)
            4'h4, 4'hB: begin sub = 0; cy = 0; end
            4'h5: begin sub = 0; cy = longint'(fin[1]); end
            4'h2, 4'hA: begin sub = 1; cy = 0; end
            4'h6: begin sub = 1; cy = longint'(!fin[1]); end
            4'h3: begin sub = 1; cy = 0; ux = longint'(s); uy = longint'(a); end
            4'h7: begin sub = 1; cy = longint'(!fin[1]); ux = longint'(s); uy = longint'(a); end
            default: arith = 0;
        endcase
        sx = longint'($signed(ux[31:0]));
        sy = longint'($signed(uy[31:0]));
        c = 0; v = 0;
        if (arith) begin
            if (sub) begin
                u = ux - uy - cy; sv = sx - sy - cy; c = (u >= 0);
            end else begin
                u = ux + uy + cy; sv = sx + sy + cy; c = (u > 64'hFFFF_FFFF);
            end
            v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
            r = u[31:0];
        end else begin
            case (op)
                4'h0, 4'h8: r = a & s;
                4'h1, 4'h9: r = a ^ s;
                4'hC: r = a | s;
                4'hE: r = a & ~s;
                4'hD: r = s;
                default: r = ~s;
            endcase
            c = sc; v = fin[0];
        end
        we = (op[3:2] != 2'b10);
        if (sf || op[3:2] == 2'b10) fo = {r[31], r == 32'd0, c, v};
        else fo = fin;
    endfunction

    task automatic check(input string tag, input logic [31:0] er, input logic ew, input logic [3:0] ef);
        checks++;
        if (result !== er || result_we !== ew || flags_out !== ef) begin
            errors++;
            $display("FAIL %s: got r=%h we=%b f=%b, expected r=%h we=%b f=%b",
                     tag, result, result_we, flags_out, er, ew, ef);
        end
    endtask

    // called at a falling edge; drives, waits one rising edge, checks at the next falling edge
    task automatic step(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] k, input logic [4:0] n, input logic [3:0] op,
                        input logic sf, input logic [3:0] fin);
        logic [31:0] er; logic ew; logic [3:0] ef;
        opnd_a = a; opnd_b = b; shift_kind = k; shift_amt = n;
        opcode = op; set_flags = sf; flags_in = fin;
        model(a, b, k, n, op, sf, fin, er, ew, ef);
        @(posedge clk);
        @(negedge clk);
        check(tag, er, ew, ef);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] pr; logic pw; logic [3:0] pf;
        // R1: reset state
        opnd_a = 32'hFFFF_FFFF; opcode = 4'h4; set_flags = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", 32'd0, 1'b0, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R9 arithmetic
        step("R4 ADD",            32'd5, 32'd7, 2'd0, 5'd0, 4'h4, 1'b0, 4'b0000);
        step("R9 ADD ovf",        32'h7FFF_FFFF, 32'd1, 2'd0, 5'd0, 4'h4, 1'b1, 4'b0000);
        step("R9 ADD carry R8 Z", 32'hFFFF_FFFF, 32'd1, 2'd0, 5'd0, 4'h4, 1'b1, 4'b0000);
        step("R4 ADC",            32'd10, 32'd20, 2'd0, 5'd0, 4'h5, 1'b1, 4'b0010);
        step("R9 SUB borrow",     32'd5, 32'd7, 2'd0, 5'd0, 4'h2, 1'b1, 4'b0000);
        step("R9 SUB no borrow",  32'd7, 32'd5, 2'd0, 5'd0, 4'h2, 1'b1, 4'b0000);
        step("R4 SBC",            32'd7, 32'd5, 2'd0, 5'd0, 4'h6, 1'b1, 4'b0000);
        step("R4 RSB",            32'd3, 32'd10, 2'd0, 5'd0, 4'h3, 1'b1, 4'b0000);
        step("R4 RSC",            32'd3, 32'd10, 2'd0, 5'd0, 4'h7, 1'b1, 4'b0010);
        step("R9 SUB ovf",        32'h8000_0000, 32'd1, 2'd0, 5'd0, 4'h2, 1'b1, 4'b0000);
        // R5 logical and moves
        step("R5 AND",            32'hF0F0_1234, 32'h0FF0_FFFF, 2'd0, 5'd0, 4'h0, 1'b1, 4'b0001);
        step("R5 EOR",            32'hAAAA_5555, 32'hFFFF_0000, 2'd0, 5'd0, 4'h1, 1'b0, 4'b0110);
        step("R5 ORR",            32'h0000_00F0, 32'h0000_000F, 2'd0, 5'd0, 4'hC, 1'b1, 4'b0000);
        step("R5 BIC",            32'hFFFF_FFFF, 32'h0000_FF00, 2'd0, 5'd0, 4'hE, 1'b1, 4'b0000);
        step("R5 MOV ignores a",  32'hDEAD_BEEF, 32'h0000_0042, 2'd0, 5'd0, 4'hD, 1'b1, 4'b0000);
        step("R5 MVN ignores a",  32'h1234_5678, 32'h0000_0000, 2'd0, 5'd0, 4'hF, 1'b1, 4'b0001);
        // R6 / R8 compare and test group
        step("R6 CMP equal",      32'd9, 32'd9, 2'd0, 5'd0, 4'hA, 1'b0, 4'b0000);
        step("R6 CMN",            32'hFFFF_FFFF, 32'd2, 2'd0, 5'd0, 4'hB, 1'b0, 4'b1000);
        step("R6 TST",            32'h0000_00F0, 32'h0000_000F, 2'd0, 5'd0, 4'h8, 1'b0, 4'b0011);
        step("R6 TEQ",            32'h8000_0000, 32'd0, 2'd0, 5'd0, 4'h9, 1'b0, 4'b0101);
        // R7 no update
        step("R7 hold flags",     32'hFFFF_FFFF, 32'd1, 2'd0, 5'd0, 4'h4, 1'b0, 4'b1010);
        step("R7 hold on shift",  32'd0, 32'h8000_0001, 2'd1, 5'd1, 4'hD, 1'b0, 4'b0000);
        // R2 / R3 / R10 shifter
        step("R2 LSL",            32'd0, 32'h0000_00FF, 2'd0, 5'd4, 4'hD, 1'b1, 4'b0000);
        step("R3 LSL carry",      32'd0, 32'h8000_0000, 2'd0, 5'd1, 4'hD, 1'b1, 4'b0000);
        step("R2 LSR 31",         32'd0, 32'hC000_0000, 2'd1, 5'd31, 4'hD, 1'b1, 4'b0000);
        step("R2 ASR neg",        32'd0, 32'h8000_0010, 2'd2, 5'd4, 4'hD, 1'b1, 4'b0000);
        step("R2 ROR",            32'd0, 32'h1234_5680, 2'd3, 5'd8, 4'hD, 1'b1, 4'b0000);
        step("R3 zero amt keeps C", 32'd0, 32'hFFFF_FFFF, 2'd3, 5'd0, 4'hD, 1'b1, 4'b0010);
        step("R10 TST shifter C", 32'hFFFF_FFFF, 32'h0000_0003, 2'd1, 5'd1, 4'h8, 1'b0, 4'b0001);
        step("R2 ADD shifted",    32'd1, 32'd3, 2'd0, 5'd2, 4'h4, 1'b1, 4'b0000);

        // R1 latency: output unchanged before the next rising edge
        model(opnd_a, opnd_b, shift_kind, shift_amt, opcode, set_flags, flags_in, pr, pw, pf);
        opnd_a = 32'h5555_5555; opcode = 4'hF; flags_in = 4'b1111;
        #1;
        check("R1 registered", pr, pw, pf);
        @(posedge clk);
        @(negedge clk);

        // random patterns across all requirements
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 7 == 0) rb = 32'h8000_0000 >> (i % 32);
            step("R2-R10 random", ra, rb, 2'($urandom), 5'($urandom), 4'($urandom),
                 1'($urandom), 4'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule